// File: doc/BRIEF.md
# Bus Controller Interrupt Status Register

This block holds the interrupt status of a bus interface controller that contains a script engine. It keeps three flags that a host processor can see. The first is a connection flag that the hardware tracks. The second is an on-the-fly interrupt flag that a non-halting script instruction raises and that the host clears by writing a one to it. The third is a read-only summary of latched bus interrupt events. It also carries a soft reset bit that clears itself, and it shows the level of a DMA pending input that is produced elsewhere.

Event pulses come from the bus state machine and from the script engine. Each bus interrupt source is caught in its own sticky flag. The host clears these flags by reading a separate source status register, which reaches this block as a read strobe. A single registered interrupt line tells the host that something needs attention.

The host reads the status word as a plain combinational view of the stored state. It writes through a one-cycle write strobe.

Top module: `bus_irq_status`

## Requirements
- R1: After reset, every bit of `host_rdata` reads 0 (with `dma_pend` low) and `irq_o` is 0.
- R2: Bit 3 of `host_rdata` (connected) becomes 1 one cycle after any of these pulses: `ev_sel_done`, or `ev_sel_resp`. An `ev_arb_won` pulse also sets it, but only while `low_level` is 1; otherwise it has no effect.
- R3: The connected bit becomes 0 one cycle after an `ev_disc` pulse. If a set event and `ev_disc` arrive in the same cycle, the bit ends up 1.
- R4: Bit 2 of `host_rdata` (on-the-fly) becomes 1 one cycle after a `fly_pulse`. It stays 1 through idle cycles and through `src_rd` strobes.
- R5: A host write with bit 2 = 1 clears the on-the-fly bit. A write with bit 2 = 0 leaves it unchanged. If a `fly_pulse` arrives in the same cycle as a clearing write, the bit ends up 1.
- R6: Bit 1 of `host_rdata` (bus pending) becomes 1 one cycle after a source event, provided the event counts. A phase mismatch counts only when `is_target` = 0. An attention assertion counts only when `is_target` = 1. Arbitration done and selection timeout count in either role.
- R7: The bus pending bit stays 1 until a `src_rd` strobe, which clears it one cycle later. A source event in the same cycle as `src_rd` keeps the bit at 1.
- R8: `irq_o` equals the OR of the on-the-fly bit, the bus pending bit and `dma_pend`, delayed by one register. It changes one cycle after the status bits or the input change.
- R9: A host write with bit 6 = 1 makes bit 6 read 1 for exactly one cycle. In the following cycle, the connected, on-the-fly and bus pending bits all read 0.
- R10: Bit 0 of `host_rdata` shows `dma_pend` directly, with no delay. Bits 4, 5 and 7 read 0. Host writes have no effect on bits 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_sel_done | input | 1 | Pulse: selection completed successfully |
| ev_sel_resp | input | 1 | Pulse: responded to a selection or reselection started by another device |
| ev_arb_won | input | 1 | Pulse: arbitration won |
| low_level | input | 1 | Low-level mode enable |
| ev_disc | input | 1 | Pulse: disconnected from the bus |
| is_target | input | 1 | Current role: 1 = target, 0 = initiator |
| ev_phase_mm | input | 1 | Pulse: phase mismatch |
| ev_atn | input | 1 | Pulse: attention line asserted |
| ev_arb_done | input | 1 | Pulse: arbitration sequence completed |
| ev_sel_to | input | 1 | Pulse: selection or reselection timeout |
| src_rd | input | 1 | Strobe: host read of the source status register |
| fly_pulse | input | 1 | Pulse: script engine executed an on-the-fly interrupt instruction |
| dma_pend | input | 1 | DMA interrupt pending level |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every event pulse is sampled at a rising edge, and the status bit it affects can be read at the next falling edge. The one exception is the DMA bit, which is visible in the same cycle. `irq_o` comes one register later: it is due one full cycle after the status bit that drives it. The bench drives all inputs at falling edges, steps one rising edge at a time, and samples after each step. For the interrupt line it takes one extra step, and it also checks that the line has not yet moved in the cycle where the status bit first appears.

// File: rtl/bis_pkg.sv
package bis_pkg;
    localparam int DW       = 8;
    localparam int NSRC     = 4;
    localparam int B_DMA    = 0;
    localparam int B_BUS    = 1;
    localparam int B_FLY    = 2;
    localparam int B_CONN   = 3;
    localparam int B_SRST   = 6;
    // source vector order inside the latch bank
    localparam int S_PHASE  = 0;
    localparam int S_ATN    = 1;
    localparam int S_ARB    = 2;
    localparam int S_SELTO  = 3;
endpackage

// File: rtl/bis_conn_track.sv
module bis_conn_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_sel,
    input  logic set_resp,
    input  logic set_arb,
    input  logic low_level,
    input  logic clr_disc,
    input  logic clr_soft,
    output logic conn_o
);
    typedef struct packed {
        logic conn;
    } conn_st_t;

    conn_st_t st_d, st_q;
    logic     set_any;

    always_comb begin
        st_d    = st_q;
        set_any = set_sel | set_resp | (set_arb & low_level);
        if (clr_soft)
            st_d.conn = 1'b0;
        else if (set_any)
            st_d.conn = 1'b1;
        else if (clr_disc)
            st_d.conn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conn_o = st_q.conn;

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_sel || set_resp) && !clr_soft) |=> conn_o);
    p_arb_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_arb && low_level && !clr_soft) |=> conn_o);
    p_disc_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_disc && !set_sel && !set_resp && !(set_arb && low_level)) |=> !conn_o);
    p_soft_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_soft |=> !conn_o);
endmodule

// File: rtl/bis_fly_flag.sv
module bis_fly_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_fly,
    input  logic w1c,
    input  logic clr_soft,
    output logic fly_o
);
    typedef struct packed {
        logic fly;
    } fly_st_t;

    fly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_soft)
            st_d.fly = 1'b0;
        else if (set_fly)
            st_d.fly = 1'b1;
        else if (w1c)
            st_d.fly = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fly_o = st_q.fly;

    p_fly_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fly && !clr_soft) |=> fly_o);
    p_fly_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !set_fly) |=> !fly_o);
    p_fly_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_fly && !w1c && !clr_soft) |=> $stable(fly_o));
endmodule

// File: rtl/bis_src_latch.sv
module bis_src_latch #(
    parameter int N = bis_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd_clr,
    input  logic         clr_soft,
    output logic         pend_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } src_st_t;

    src_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr_soft)
                st_d.flag[i] = 1'b0;
            else if (ev[i])
                st_d.flag[i] = 1'b1;
            else if (rd_clr)
                st_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = |st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_src_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[g] && !clr_soft) |=> pend_o);
    end

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev == '0) |=> !pend_o);
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !rd_clr && !clr_soft) |=> pend_o);
endmodule

// File: rtl/bus_irq_status.sv
module bus_irq_status
    import bis_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_sel_done,
    input  logic          ev_sel_resp,
    input  logic          ev_arb_won,
    input  logic          low_level,
    input  logic          ev_disc,
    input  logic          is_target,
    input  logic          ev_phase_mm,
    input  logic          ev_atn,
    input  logic          ev_arb_done,
    input  logic          ev_sel_to,
    input  logic          src_rd,
    input  logic          fly_pulse,
    input  logic          dma_pend,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq_o
);
    localparam logic [DW-1:0] W_MASK = DW'((1 << B_FLY) | (1 << B_SRST));

    typedef struct packed {
        logic srst;
        logic irq;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             conn, fly, bus_pend;
    logic             fly_w1c;
    logic [NSRC-1:0]  src_ev;

    assign fly_w1c = host_wr & host_wdata[B_FLY];

    always_comb begin
        src_ev          = '0;
        src_ev[S_PHASE] = ev_phase_mm & ~is_target;
        src_ev[S_ATN]   = ev_atn & is_target;
        src_ev[S_ARB]   = ev_arb_done;
        src_ev[S_SELTO] = ev_sel_to;
    end

    bis_conn_track u_conn (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_sel   (ev_sel_done),
        .set_resp  (ev_sel_resp),
        .set_arb   (ev_arb_won),
        .low_level (low_level),
        .clr_disc  (ev_disc),
        .clr_soft  (st_q.srst),
        .conn_o    (conn)
    );

    bis_fly_flag u_fly (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_fly  (fly_pulse),
        .w1c      (fly_w1c),
        .clr_soft (st_q.srst),
        .fly_o    (fly)
    );

    bis_src_latch #(.N(NSRC)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (src_ev),
        .rd_clr   (src_rd),
        .clr_soft (st_q.srst),
        .pend_o   (bus_pend)
    );

    always_comb begin
        st_d      = st_q;
        st_d.srst = host_wr & host_wdata[B_SRST];
        st_d.irq  = fly | bus_pend | dma_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        host_rdata         = '0;
        host_rdata[B_DMA]  = dma_pend;
        host_rdata[B_BUS]  = bus_pend;
        host_rdata[B_FLY]  = fly;
        host_rdata[B_CONN] = conn;
        host_rdata[B_SRST] = st_q.srst;
    end

    assign irq_o = st_q.irq;

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(fly | bus_pend | dma_pend)));
    p_srst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.srst && !(host_wr && host_wdata[B_SRST])) |=> !host_rdata[B_SRST]);
    p_other_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ((host_wdata & ~W_MASK) != '0) && !host_wdata[B_FLY]
         && !fly_pulse && !st_q.srst) |=> $stable(fly));
    p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[7:4] & 4'b1011) == 4'b0000);
endmodule

// File: tb/test_bus_irq_status.sv
module test_bus_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_sel_done = 0, ev_sel_resp = 0, ev_arb_won = 0, low_level = 0;
    logic       ev_disc = 0, is_target = 0, ev_phase_mm = 0, ev_atn = 0;
    logic       ev_arb_done = 0, ev_sel_to = 0, src_rd = 0, fly_pulse = 0;
    logic       dma_pend = 0, host_wr = 0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_o;
    int         total = 0, bad = 0;
    bit         reported = 0;

    always #4 clk = ~clk;

    bus_irq_status i_bus_irq_status (
        .clk(clk), .rst_n(rst_n), .ev_sel_done(ev_sel_done), .ev_sel_resp(ev_sel_resp),
        .ev_arb_won(ev_arb_won), .low_level(low_level), .ev_disc(ev_disc),
        .is_target(is_target), .ev_phase_mm(ev_phase_mm), .ev_atn(ev_atn),
        .ev_arb_done(ev_arb_done), .ev_sel_to(ev_sel_to), .src_rd(src_rd),
        .fly_pulse(fly_pulse), .dma_pend(dma_pend), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ev_sel_done = 0; ev_sel_resp = 0; ev_arb_won = 0; ev_disc = 0;
        ev_phase_mm = 0; ev_atn = 0; ev_arb_done = 0; ev_sel_to = 0;
        src_rd = 0; fly_pulse = 0; host_wr = 0; host_wdata = '0;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(logic [7:0] d);
        host_wr = 1; host_wdata = d; step(); idle();
    endtask

    task automatic clear_all();
        idle(); dma_pend = 0; ev_disc = 1; src_rd = 1; host_wr = 1; host_wdata = 8'h04;
        step(); idle(); step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        report();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        rst_n = 1;
        step();
        chk("R1 after release", host_rdata, 8'h00);

        // R2 connect paths
        ev_sel_done = 1; step(); idle();
        chk("R2 sel_done", host_rdata & 8'h08, 8'h08);
        ev_disc = 1; step(); idle();
        chk("R3 disc", host_rdata & 8'h08, 8'h00);
        ev_sel_resp = 1; step(); idle();
        chk("R2 sel_resp", host_rdata & 8'h08, 8'h08);
        ev_disc = 1; step(); idle();
        low_level = 0; ev_arb_won = 1; step(); idle();
        chk("R2 arb ignored when not low level", host_rdata & 8'h08, 8'h00);
        low_level = 1; ev_arb_won = 1; step(); idle();
        chk("R2 arb in low level", host_rdata & 8'h08, 8'h08);
        low_level = 0;
        // R3 collision
        ev_disc = 1; ev_sel_done = 1; step(); idle();
        chk("R3 set wins", host_rdata & 8'h08, 8'h08);

        // R10 writes do not touch bits 0,1,3
        wr(8'hBB);
        chk("R10 ignored write bits", host_rdata, 8'h08);
        dma_pend = 1; #1;
        chk("R10 dma live", host_rdata & 8'h01, 8'h01);
        dma_pend = 0; #1;
        clear_all();

        // R4 on-the-fly set and hold
        fly_pulse = 1; step(); idle();
        chk("R4 fly set", host_rdata, 8'h04);
        chk("R8 irq lag", {7'd0, irq_o}, 8'h00);
        src_rd = 1; step(); idle();
        chk("R4 src_rd no clear", host_rdata, 8'h04);
        step(); step();
        chk("R4 hold", host_rdata, 8'h04);
        // R5 write-one-to-clear
        wr(8'hFB & 8'hBF);
        chk("R5 write zero keeps", host_rdata & 8'h04, 8'h04);
        wr(8'h04);
        chk("R5 w1c", host_rdata & 8'h04, 8'h00);
        fly_pulse = 1; host_wr = 1; host_wdata = 8'h04; step(); idle();
        chk("R5 set wins", host_rdata & 8'h04, 8'h04);
        clear_all();

        // R6/R7 sweep over sources and roles
        for (int role = 0; role < 2; role++) begin
            for (int s = 0; s < 4; s++) begin
                logic [7:0] exp;
                is_target = role[0];
                case (s)
                    0: ev_phase_mm = 1;
                    1: ev_atn = 1;
                    2: ev_arb_done = 1;
                    default: ev_sel_to = 1;
                endcase
                exp = ((s == 0 && role == 0) || (s == 1 && role == 1) || s >= 2) ? 8'h02 : 8'h00;
                step(); idle();
                chk("R6 source latch", host_rdata & 8'h02, exp);
                step();
                chk("R7 hold", host_rdata & 8'h02, exp);
                src_rd = 1; step(); idle();
                chk("R7 rd clears", host_rdata & 8'h02, 8'h00);
            end
        end
        is_target = 0;
        ev_arb_done = 1; src_rd = 1; step(); idle();
        chk("R7 event beats read", host_rdata & 8'h02, 8'h02);
        src_rd = 1; step(); idle();

        // R8 interrupt line sweep
        for (int c = 0; c < 8; c++) begin
            fly_pulse = c[0]; ev_arb_done = c[1]; dma_pend = c[2];
            step(); idle();
            step();
            chk("R8 irq or", {7'd0, irq_o}, {7'd0, (c != 0)});
            clear_all();
            chk("R8 irq drops", {7'd0, irq_o}, 8'h00);
        end

        // R9 soft reset
        ev_sel_done = 1; fly_pulse = 1; ev_sel_to = 1; step(); idle();
        chk("R9 pre", host_rdata, 8'h0E);
        wr(8'h40);
        chk("R9 bit high", host_rdata & 8'h40, 8'h40);
        step();
        chk("R9 self clear", host_rdata, 8'h00);

        report();
    end
endmodule